// File: doc/BRIEF.md
# Asynchronous Memory Strobe Filter

This block sits between an asynchronous external-memory controller and a byte-wide target, such as a register file in programmable logic or a static RAM. For one logical access the controller issues a group of four strobes with incrementing low address bits. The filter samples the controller's chip select, output enable, write enable, byte mask and address with a fast local clock. It passes only the first read strobe of each group to the target. Software left-shifts its addresses, so the filter drops the low address bits and the target sees a single location per group.

Read data is captured while the forwarded read strobe is active. It is then held on the return path for the rest of the group, so every extra read the controller makes returns the same byte. Write enable reaches the target only when the matching byte-lane mask is also active. In narrow (8-bit) mode only lane 0 can write. In wide (16-bit) mode each lane follows its own mask. The mode input is only changed while chip select is inactive.

Top module: `mem_strobe_filter`

## Requirements
- R1: Within one group (chip select held low, shifted address unchanged), exactly one falling edge of output enable reaches `tgtOeN`, however many of the four controller read pulses occur.
- R2: A group ends when chip select goes high or when the shifted address changes. The next read pulse after either event is forwarded again.
- R3: `tgtOeN` goes low 3 clock edges after `busOeN` goes low, and high 3 clock edges after `busOeN` goes high. The forwarded pulse is neither stretched nor delayed beyond this.
- R4: `tgtAddr` equals `busAddr >> 3` when `wideMode` is 0 (8-bit bus) and `busAddr >> 2` when `wideMode` is 1 (16-bit bus), with 3 clock edges of latency.
- R5: `tgtWeN[0]` is low only when chip select, write enable and byte mask bit 0 were all low 3 edges earlier. Write enable with chip select high produces no strobe.
- R6: When `wideMode` is 0, `tgtWeN[1]` stays high whatever `busMaskN[1]` does.
- R7: When `wideMode` is 1, `tgtWeN[1]` goes low only when chip select, write enable and byte mask bit 1 are all low.
- R8: `busRdData` takes the value of `tgtRdData` only while the forwarded read strobe is active. It holds that value through the extra pulses of the group and after it.
- R9: After reset, `tgtCsN`, `tgtOeN` and both bits of `tgtWeN` are high, and `busRdData` is 0.
- R10: A group of more than four read pulses still forwards only the first one, because the pulse count saturates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busCsN | input | 1 | Controller chip select, active low |
| busOeN | input | 1 | Controller output enable, active low |
| busWeN | input | 1 | Controller write enable, active low |
| busMaskN | input | 2 | Controller byte-lane mask, active low, bit i for lane i |
| busAddr | input | ADDR_W | Controller address |
| wideMode | input | 1 | 0 = 8-bit bus, 1 = 16-bit bus |
| busRdData | output | DATA_W | Held read data returned to the controller |
| tgtRdData | input | DATA_W | Read data from the target |
| tgtCsN | output | 1 | Target chip select, active low |
| tgtOeN | output | 1 | Filtered target output enable, active low |
| tgtWeN | output | 2 | Qualified per-lane target write strobes, active low |
| tgtAddr | output | ADDR_W-2 | Remapped target address |

## Verification
Every controller input passes through two sampling flops and one output register. So strobes, chip select and address appear at the target 3 rising edges after they change on the bus. The bench drives inputs on falling edges and reads outputs 1 ns after rising edges. The latency check reads `tgtOeN` after the second edge, where it must be unchanged, and again after the third edge, where it must have moved. Counts of forwarded pulses and observed write strobes are collected by a monitor over a whole group. They are compared only after the group has ended and at least four idle cycles have passed. Read data is compared once the forwarded pulse has ended, when the last capture edge has gone by.

// File: rtl/strobe_filter_pkg.sv
package strobe_filter_pkg;
  typedef enum logic {
    BUS_NARROW = 1'b0,
    BUS_WIDE   = 1'b1
  } busWidth_e;

  typedef struct packed {
    logic       oeFwd;
    logic [1:0] weLane;
    logic       csSel;
  } strobe_t;

  localparam int LANES = 2;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] INIT = '0,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       pipe[s] <= INIT;
      else if (s == 0) pipe[s] <= d;
      else             pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/strobe_ctrl.sv
module strobe_ctrl
  import strobe_filter_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sCsN,
  input  logic             sOeN,
  input  logic             sWeN,
  input  logic [LANES-1:0] sMaskN,
  input  busWidth_e        sMode,
  input  logic             addrChg,
  output strobe_t          stb
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             oePrev;
  logic [CNT_W-1:0] pulseCnt;
  logic [CNT_W-1:0] effCnt;
  logic             oeFall;
  logic             grpClear;
  logic             passQ;
  logic [LANES-1:0] weQ;
  logic             csQ;
  logic             writeOn;

  assign oeFall   = oePrev & ~sOeN & ~sCsN;
  assign grpClear = sCsN | addrChg;
  assign effCnt   = grpClear ? '0 : pulseCnt;
  assign writeOn  = ~sCsN & ~sWeN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oePrev   <= 1'b1;
      pulseCnt <= '0;
      passQ    <= 1'b0;
    end else begin
      oePrev <= sOeN;
      if (oeFall) begin
        pulseCnt <= (effCnt == CNT_MAX) ? CNT_MAX : effCnt + 1'b1;
        passQ    <= (effCnt == '0);
      end else begin
        pulseCnt <= effCnt;
        if (sOeN || sCsN) passQ <= 1'b0;
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic laneOn;
    if (l == 0) begin : g_base
      assign laneOn = 1'b1;
    end else begin : g_wide
      assign laneOn = (sMode == BUS_WIDE);
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) weQ[l] <= 1'b0;
      else       weQ[l] <= writeOn & ~sMaskN[l] & laneOn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) csQ <= 1'b0;
    else       csQ <= ~sCsN;
  end

  assign stb.oeFwd  = passQ;
  assign stb.weLane = weQ;
  assign stb.csSel  = csQ;
endmodule

// File: rtl/strobe_datapath.sv
module strobe_datapath
  import strobe_filter_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int TADDR_W = ADDR_W - 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  sAddr,
  input  busWidth_e          sMode,
  input  strobe_t            stb,
  input  logic [DATA_W-1:0]  tgtRdData,
  output logic               addrChg,
  output logic [TADDR_W-1:0] tgtAddr,
  output logic [DATA_W-1:0]  busRdData
);
  logic [TADDR_W-1:0] shifted;
  logic [TADDR_W-1:0] addrQ;
  logic [DATA_W-1:0]  dataQ;

  always_comb begin
    if (sMode == BUS_WIDE) shifted = TADDR_W'(sAddr >> 2);
    else                   shifted = TADDR_W'(sAddr >> 3);
  end

  assign addrChg = (shifted != addrQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
    end else begin
      addrQ <= shifted;
      if (stb.oeFwd) dataQ <= tgtRdData;
    end
  end

  assign tgtAddr   = addrQ;
  assign busRdData = dataQ;
endmodule

// File: rtl/mem_strobe_filter.sv
module mem_strobe_filter
  import strobe_filter_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int TADDR_W = ADDR_W - 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busCsN,
  input  logic               busOeN,
  input  logic               busWeN,
  input  logic [1:0]         busMaskN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               wideMode,
  output logic [DATA_W-1:0]  busRdData,
  input  logic [DATA_W-1:0]  tgtRdData,
  output logic               tgtCsN,
  output logic               tgtOeN,
  output logic [1:0]         tgtWeN,
  output logic [TADDR_W-1:0] tgtAddr
);
  localparam int CTL_W  = 3 + LANES + 1;
  localparam int SYNC_W = CTL_W + ADDR_W;
  localparam logic [SYNC_W-1:0] SYNC_INIT = {{(CTL_W-1){1'b1}}, 1'b0, {ADDR_W{1'b0}}};

  logic [SYNC_W-1:0] syncIn, syncOut;
  logic              sCsN, sOeN, sWeN, sModeBit;
  logic [LANES-1:0]  sMaskN;
  logic [ADDR_W-1:0] sAddr;
  busWidth_e         sMode;
  strobe_t           stb;
  logic              addrChg;

  assign syncIn = {busCsN, busOeN, busWeN, busMaskN, wideMode, busAddr};

  strobe_sync #(.W(SYNC_W), .INIT(SYNC_INIT), .STAGES(2)) syncI (
    .clk(clk), .rstN(rstN), .d(syncIn), .q(syncOut)
  );

  assign {sCsN, sOeN, sWeN, sMaskN, sModeBit, sAddr} = syncOut;
  assign sMode = busWidth_e'(sModeBit);

  strobe_ctrl #(.CNT_W(2)) ctrlI (
    .clk(clk), .rstN(rstN), .sCsN(sCsN), .sOeN(sOeN), .sWeN(sWeN),
    .sMaskN(sMaskN), .sMode(sMode), .addrChg(addrChg), .stb(stb)
  );

  strobe_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dpI (
    .clk(clk), .rstN(rstN), .sAddr(sAddr), .sMode(sMode), .stb(stb),
    .tgtRdData(tgtRdData), .addrChg(addrChg), .tgtAddr(tgtAddr),
    .busRdData(busRdData)
  );

  assign tgtCsN = ~stb.csSel;
  assign tgtOeN = ~stb.oeFwd;
  assign tgtWeN = ~stb.weLane;
endmodule

// File: rtl/mem_strobe_filter_chk.sv
module mem_strobe_filter_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int TADDR_W = ADDR_W - 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               busCsN,
  input logic               busOeN,
  input logic               busWeN,
  input logic [1:0]         busMaskN,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               wideMode,
  input logic [DATA_W-1:0]  busRdData,
  input logic [DATA_W-1:0]  tgtRdData,
  input logic               tgtCsN,
  input logic               tgtOeN,
  input logic [1:0]         tgtWeN,
  input logic [TADDR_W-1:0] tgtAddr
);
  logic [2:0] upCnt;
  logic       ready;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             upCnt <= '0;
    else if (upCnt != 3'd4) upCnt <= upCnt + 3'd1;
  end
  assign ready = (upCnt == 3'd4);

  // R3
  oe_fall_lag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ready && $fell(tgtOeN)) |-> (!$past(busOeN, 3) && !$past(busCsN, 3)));

  // R3
  oe_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ready && $past(busOeN, 3)) |-> tgtOeN);

  // R4
  addr_map_chk: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (tgtAddr == ($past(wideMode, 3) ? TADDR_W'($past(busAddr, 3) >> 2)
                                              : TADDR_W'($past(busAddr, 3) >> 3))));

  // R5
  we_lane0_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !tgtWeN[0]) |-> (!$past(busWeN, 3) && !$past(busMaskN[0], 3) && !$past(busCsN, 3)));

  // R6
  narrow_lane1_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !$past(wideMode, 3)) |-> tgtWeN[1]);

  // R7
  wide_lane1_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !tgtWeN[1]) |-> (!$past(busMaskN[1], 3) && !$past(busWeN, 3)));

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(busRdData) |-> $past(!tgtOeN));

  // R1
  oe_under_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tgtOeN |-> !tgtCsN);
endmodule

bind mem_strobe_filter mem_strobe_filter_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chkI (.*);

// File: tb/tb_mem_strobe_filter.sv
`timescale 1ns/1ps
module tb_mem_strobe_filter;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int TADDR_W = ADDR_W - 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busCsN = 1'b1, busOeN = 1'b1, busWeN = 1'b1, wideMode = 1'b0;
  logic [1:0] busMaskN = 2'b11;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [DATA_W-1:0] busRdData, tgtRdData;
  logic tgtCsN, tgtOeN;
  logic [1:0] tgtWeN;
  logic [TADDR_W-1:0] tgtAddr;

  int runCnt = 0, failCnt = 0;
  int fallCnt = 0;
  logic [TADDR_W-1:0] seenAddr = '0;
  logic [1:0] weLow = 2'b00;
  logic prevOe = 1'b1;
  bit done = 0;

  always #2 clk = ~clk;

  mem_strobe_filter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (.*);

  function automatic logic [DATA_W-1:0] memVal(logic [TADDR_W-1:0] a);
    return DATA_W'((a * 13 + 7) ^ (a >> 3));
  endfunction

  assign tgtRdData = memVal(tgtAddr);

  always begin
    @(posedge clk); #1;
    if (prevOe && !tgtOeN) begin fallCnt++; seenAddr = tgtAddr; end
    prevOe = tgtOeN;
    weLow |= ~tgtWeN;
  end

  task automatic check(bit ok, string req, longint act, longint exp);
    runCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
      $finish;
    end
  endtask

  function automatic logic [ADDR_W-1:0] busBase(int la, bit wide);
    return wide ? ADDR_W'(la << 2) : ADDR_W'(la << 3);
  endfunction

  task automatic pulseOe(logic [ADDR_W-1:0] a);
    busAddr = a; idle(2);
    busOeN = 0; idle(6);
    busOeN = 1; idle(4);
  endtask

  // One read group with given pulse count; checks R1/R4/R8 (R10 when pulses > 4)
  task automatic doRead(int la, bit wide, int pulses);
    logic [DATA_W-1:0] firstData;
    logic [TADDR_W-1:0] expA;
    expA = TADDR_W'(la);
    @(negedge clk); wideMode = wide; idle(2);
    busCsN = 0; fallCnt = 0;
    for (int p = 0; p < pulses; p++) begin
      pulseOe(busBase(la, wide) + ADDR_W'(p % 4));
      if (p == 0) firstData = busRdData;
    end
    busCsN = 1; idle(4);
    if (pulses > 4) check(fallCnt == 1, "R10 saturated count", fallCnt, 1);
    else            check(fallCnt == 1, "R1 single forward", fallCnt, 1);
    check(seenAddr == expA, "R4 address map", seenAddr, expA);
    check(busRdData == memVal(expA), "R8 data latched", busRdData, memVal(expA));
    check(busRdData == firstData, "R8 data held", busRdData, firstData);
  endtask

  // Write; checks R5/R6/R7
  task automatic doWrite(int la, bit wide, logic [1:0] mask, bit csOn);
    logic [1:0] expLow;
    @(negedge clk); wideMode = wide; busAddr = busBase(la, wide); idle(2);
    busCsN = ~csOn; idle(2);
    weLow = 2'b00;
    busWeN = 0; busMaskN = mask; idle(6);
    busWeN = 1; busMaskN = 2'b11; idle(4);
    busCsN = 1; idle(2);
    expLow[0] = csOn & ~mask[0];
    expLow[1] = csOn & wide & ~mask[1];
    check(weLow[0] == expLow[0], csOn ? "R5 lane0 strobe" : "R5 no strobe without cs",
          weLow[0], expLow[0]);
    check(weLow[1] == expLow[1], wide ? "R7 lane1 wide" : "R6 lane1 narrow",
          weLow[1], expLow[1]);
  endtask

  initial begin
    #(4 * 150000);
    failCnt++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle(3);
    // R9
    check(tgtOeN === 1'b1, "R9 reset tgtOeN", tgtOeN, 1);
    check(tgtCsN === 1'b1, "R9 reset tgtCsN", tgtCsN, 1);
    check(tgtWeN === 2'b11, "R9 reset tgtWeN", tgtWeN, 3);
    check(busRdData === '0, "R9 reset data", busRdData, 0);
    rstN = 1; idle(4);

    // R3 latency of forwarded pulse
    busCsN = 0; busAddr = 16'h0040; idle(5);
    busOeN = 0;
    @(posedge clk); @(posedge clk); #1;
    check(tgtOeN == 1'b1, "R3 fall not early", tgtOeN, 1);
    @(posedge clk); #1;
    check(tgtOeN == 1'b0, "R3 fall on third edge", tgtOeN, 0);
    idle(4); busOeN = 1;
    @(posedge clk); @(posedge clk); #1;
    check(tgtOeN == 1'b0, "R3 release not early", tgtOeN, 0);
    @(posedge clk); #1;
    check(tgtOeN == 1'b1, "R3 release on third edge", tgtOeN, 1);
    idle(2); busCsN = 1; idle(4);

    // Directed reads, both modes; same address twice (R2 via cs toggle)
    doRead(5, 0, 4);
    doRead(5, 0, 4);
    doRead(9, 1, 4);
    doRead(3, 1, 6);

    // R2: address change without cs deassert starts a new group
    @(negedge clk); wideMode = 0; idle(2);
    busCsN = 0; fallCnt = 0;
    for (int p = 0; p < 4; p++) pulseOe(busBase(20, 0) + ADDR_W'(p));
    for (int p = 0; p < 4; p++) pulseOe(busBase(21, 0) + ADDR_W'(p));
    busCsN = 1; idle(4);
    check(fallCnt == 2, "R2 new group on address change", fallCnt, 2);
    check(busRdData == memVal(21), "R8 data of second group", busRdData, memVal(21));

    // Directed writes
    doWrite(7, 0, 2'b00, 1);
    doWrite(7, 0, 2'b01, 1);
    doWrite(7, 1, 2'b01, 1);
    doWrite(7, 1, 2'b10, 1);
    doWrite(7, 1, 2'b00, 0);

    // Random mix
    for (int i = 0; i < 40; i++) begin
      bit wide;
      int la;
      wide = 1'($urandom);
      la = int'($urandom_range(0, wide ? 16383 : 8191));
      if ($urandom_range(0, 1) == 0) doRead(la, wide, int'($urandom_range(1, 6)));
      else doWrite(la, wide, 2'($urandom), 1'($urandom_range(0, 3) != 0));
    end

    finishRun();
  end
endmodule